// File: doc/BRIEF.md
# Capture-Window Error and Burst Logger

This block sits on the tester side of a shift-chain upset experiment. On every data-clock edge it takes a four-bit window captured from the device under test and compares it with a window it regenerates itself. The regenerated window follows the same stimulus the device receives: all zeros, all ones, or a checkerboard that alternates phase on every capture. No cycle is skipped. Each capture that disagrees produces an event holding a cycle timestamp, the four-bit error mask and a flag. A saturating counter tracks faulted captures. A second saturating counter tracks bursts, which are faults on back-to-back captures.

A start pulse clears the timestamp, the counters, the overflow flag and the event queue. It then holds off checking for a programmable number of captures so that the regenerated pattern lines up with data that has travelled through the chain. When the device runs with its shift enable active only every other cycle, a single upset appears as a known pair of masks on two consecutive captures. With the alternating mode selected, the block marks the second capture of such a pair as a pair completion and does not count it as a burst.

Events leave through a valid/ready stream with a small internal queue. Back-pressure rules: while `ev_valid` is high and `ev_ready` is low, the event on the stream holds steady. An event is transferred on any rising edge where both are high. If a new event arrives while the queue is full, that event is lost and a sticky overflow flag is raised. Pattern, mode, latency and the counters are plain level signals.

Top module: `win_fault_logger`

## Requirements
- R1: After reset, `err_count`, `burst_count` and `overflow` are 0 and `ev_valid` is low. No capture is checked until a start pulse has been seen, so window data before the first start changes no output.
- R2: `start` is sampled at a rising edge, and no capture is checked at that edge. The `latency` value sampled with start is L. The L captures at the next L edges are not checked, and checking runs on every edge after them. With L = 0, the first edge after start is checked.
- R3: The regenerated window is selected by `pat_mode`: 00 gives 0000 and 01 gives 1111. 10 gives a checkerboard: 0101 on the first checked capture after start, then 1010 and 0101 in turn on each following checked capture. 11 behaves as 00.
- R4: On a checked capture the error mask is `win_in` XOR the regenerated window, with bit 3 leftmost. A capture with a nonzero mask is a fault. Each fault adds one to `err_count` and creates one event carrying that mask. A capture with a zero mask creates no event.
- R5: A free-running timestamp is set to zero by the start edge. An event's `ev_ts` equals k-1 for a fault captured at the k-th rising edge after the start edge.
- R6: `burst_count` adds one for each fault whose immediately preceding edge was also a checked, faulted capture. This does not apply to pair completions (R7).
- R7: With `alt_en` high, a fault with mask 0010 directly after a fault with mask 1000 is a pair completion. So is a fault with mask 0001 directly after a fault with mask 0100. A pair completion sets `ev_paired` in its event and does not add to `burst_count`, though it still adds to `err_count`. With `alt_en` low, `ev_paired` is 0 and such pairs count as bursts.
- R8: `err_count` and `burst_count` stop at 2^CNT_W-1 and never wrap.
- R9: Events leave in the order they occurred. While `ev_valid` is high and `ev_ready` is low, `ev_valid`, `ev_ts`, `ev_mask` and `ev_paired` do not change.
- R10: The queue holds FIFO_DEPTH events. A fault at an edge where the queue already holds FIFO_DEPTH events is dropped, even if a transfer happens at that same edge, and `overflow` goes high. `overflow` stays high until the next start.
- R11: A start edge empties the queue and clears `overflow`, `err_count`, `burst_count` and the record of the previous capture. After the start edge, `ev_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock; one capture per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Restart: clears state, reloads latency |
| pat_mode | input | 2 | Expected pattern select (R3) |
| alt_en | input | 1 | Alternating-enable interpretation of pairs |
| latency | input | LAT_W | Captures to skip after start |
| win_in | input | 4 | Captured window from the device |
| ev_valid | output | 1 | Event available |
| ev_ready | input | 1 | Consumer accepts event |
| ev_ts | output | TS_W | Event timestamp |
| ev_mask | output | 4 | Event error mask |
| ev_paired | output | 1 | Event completes an alternating-enable pair |
| err_count | output | CNT_W | Saturating fault counter |
| burst_count | output | CNT_W | Saturating burst counter |
| overflow | output | 1 | Sticky dropped-event flag |

## Verification
The bench builds the block with CNT_W = 3, FIFO_DEPTH = 4 and LAT_W = 8. The narrow counters reach saturation within a ten-capture run of faults. The four-entry queue fills, and then drops events with the overflow flag raised, while the consumer holds ready low for a handful of cycles. Latency is run at 3 and at 0. This covers both the skipped-capture window and the immediate-check boundary, within short sequences that a scoreboard tracks capture by capture.

// File: rtl/wfl_pkg.sv
package wfl_pkg;

  localparam int WIN_W = 4;

  typedef enum logic [1:0] {
    PAT_ZERO  = 2'b00,
    PAT_ONE   = 2'b01,
    PAT_CHECK = 2'b10,
    PAT_RSVD  = 2'b11
  } pat_mode_e;

  // Second capture of a single upset seen under alternating enable.
  function automatic logic pair_match(input logic [WIN_W-1:0] first,
                                      input logic [WIN_W-1:0] second);
    return ((first == 4'b1000) && (second == 4'b0010)) ||
           ((first == 4'b0100) && (second == 4'b0001));
  endfunction

endpackage

// File: rtl/wfl_expect_gen.sv
module wfl_expect_gen
  import wfl_pkg::*;
#(
  parameter int LAT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic [LAT_W-1:0] latency,
  output logic             check_en,
  output logic [WIN_W-1:0] exp_win
);

  logic             running;
  logic [LAT_W-1:0] lat_cnt;
  logic             phase;
  pat_mode_e        mode_e;

  assign mode_e   = pat_mode_e'(mode);
  assign check_en = running && (lat_cnt == '0) && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      lat_cnt <= '0;
      phase   <= 1'b0;
    end else if (start) begin
      running <= 1'b1;
      lat_cnt <= latency;
      phase   <= 1'b0;
    end else begin
      if (lat_cnt != '0) lat_cnt <= lat_cnt - 1'b1;
      if (check_en)      phase   <= ~phase;
    end
  end

  always_comb begin
    unique case (mode_e)
      PAT_ONE:   exp_win = '1;
      PAT_CHECK: exp_win = phase ? 4'b1010 : 4'b0101;
      default:   exp_win = '0;
    endcase
  end

  // Checking waits for the hold-off count after start.
  AST_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (latency != '0)) |=> !check_en); // R2

  // Phase advances only on checked captures.
  AST_PHASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!check_en && !start) |=> $stable(phase)); // R3

endmodule

// File: rtl/wfl_fault_track.sv
module wfl_fault_track
  import wfl_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             check_en,
  input  logic             alt_en,
  input  logic [WIN_W-1:0] win,
  input  logic [WIN_W-1:0] exp_win,
  output logic             fault,
  output logic [WIN_W-1:0] mask,
  output logic             paired,
  output logic [CNT_W-1:0] err_cnt,
  output logic [CNT_W-1:0] burst_cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [WIN_W-1:0] prev_mask;
  logic             burst_hit;

  assign mask      = win ^ exp_win;
  assign fault     = check_en && (mask != '0);
  assign paired    = fault && alt_en && pair_match(prev_mask, mask);
  assign burst_hit = fault && (prev_mask != '0) && !paired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_mask <= '0;
      err_cnt   <= '0;
      burst_cnt <= '0;
    end else if (start) begin
      prev_mask <= '0;
      err_cnt   <= '0;
      burst_cnt <= '0;
    end else begin
      prev_mask <= check_en ? mask : '0;
      if (fault && (err_cnt != CNT_MAX))       err_cnt   <= err_cnt + 1'b1;
      if (burst_hit && (burst_cnt != CNT_MAX)) burst_cnt <= burst_cnt + 1'b1;
    end
  end

  AST_ERR_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_cnt == CNT_MAX) && !start) |=> (err_cnt == CNT_MAX)); // R8

  AST_BURST_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    ((burst_cnt == CNT_MAX) && !start) |=> (burst_cnt == CNT_MAX)); // R8

  AST_BURST_LE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    burst_cnt <= err_cnt); // R6

  AST_PAIR_NO_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (paired && !start) |=> $stable(burst_cnt)); // R7

endmodule

// File: rtl/wfl_event_fifo.sv
module wfl_event_fifo #(
  parameter int DW    = 37,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  output logic          full,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (count == CW'(DEPTH));
  assign out_valid = (count != '0);
  assign out_data  = mem[rd_ptr];
  assign do_push   = push && !full;
  assign do_pop    = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_ptr] <= push_data;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R10

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_data))); // R9

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R10

endmodule

// File: rtl/win_fault_logger.sv
module win_fault_logger
  import wfl_pkg::*;
#(
  parameter int TS_W       = 32,
  parameter int CNT_W      = 16,
  parameter int FIFO_DEPTH = 8,
  parameter int LAT_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       pat_mode,
  input  logic             alt_en,
  input  logic [LAT_W-1:0] latency,
  input  logic [3:0]       win_in,
  output logic             ev_valid,
  input  logic             ev_ready,
  output logic [TS_W-1:0]  ev_ts,
  output logic [3:0]       ev_mask,
  output logic             ev_paired,
  output logic [CNT_W-1:0] err_count,
  output logic [CNT_W-1:0] burst_count,
  output logic             overflow
);

  localparam int EV_W = TS_W + WIN_W + 1;

  logic             check_en;
  logic [WIN_W-1:0] exp_win;
  logic             fault;
  logic [WIN_W-1:0] mask;
  logic             paired;
  logic             q_full;
  logic [TS_W-1:0]  ts;
  logic [EV_W-1:0]  ev_in, ev_out;

  wfl_expect_gen #(.LAT_W(LAT_W)) u_exp (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .mode     (pat_mode),
    .latency  (latency),
    .check_en (check_en),
    .exp_win  (exp_win)
  );

  wfl_fault_track #(.CNT_W(CNT_W)) u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .check_en  (check_en),
    .alt_en    (alt_en),
    .win       (win_in),
    .exp_win   (exp_win),
    .fault     (fault),
    .mask      (mask),
    .paired    (paired),
    .err_cnt   (err_count),
    .burst_cnt (burst_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts       <= '0;
      overflow <= 1'b0;
    end else if (start) begin
      ts       <= '0;
      overflow <= 1'b0;
    end else begin
      ts <= ts + 1'b1;
      if (fault && q_full) overflow <= 1'b1;
    end
  end

  assign ev_in = {ts, mask, paired};

  wfl_event_fifo #(.DW(EV_W), .DEPTH(FIFO_DEPTH)) u_q (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (start),
    .push      (fault && !q_full),
    .push_data (ev_in),
    .full      (q_full),
    .out_valid (ev_valid),
    .out_ready (ev_ready),
    .out_data  (ev_out)
  );

  assign ev_ts     = ev_out[EV_W-1 -: TS_W];
  assign ev_mask   = ev_out[1 +: WIN_W];
  assign ev_paired = ev_out[0];

  AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!check_en && !start) |=> $stable(err_count)); // R2

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ((err_count == '0) && (burst_count == '0) && !ev_valid && !overflow)); // R11

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !start) |=> overflow); // R10

endmodule

// File: tb/sim_win_fault_logger.sv
`timescale 1ns/1ps
module sim_win_fault_logger;

  localparam int TS_W = 32, CNT_W = 3, DEPTH = 4, LAT_W = 8;
  localparam int SAT = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, alt_en = 1'b0, rdy = 1'b1;
  logic [1:0] mode = 2'b00;
  logic [LAT_W-1:0] lat = 8'd3;
  logic [3:0] win = 4'h0;
  logic ev_valid, ev_paired, overflow;
  logic [TS_W-1:0] ev_ts;
  logic [3:0] ev_mask;
  logic [CNT_W-1:0] err_count, burst_count;

  int checks = 0, errors = 0;

  // scoreboard model state
  logic [36:0] exp_q[$];
  int m_run = 0, m_lat = 0, m_phase = 0, m_tick = 0, m_err = 0, m_burst = 0, m_occ = 0, m_ovf = 0;
  logic [3:0] m_prev = 4'h0;

  always #4 clk = ~clk;

  win_fault_logger #(.TS_W(TS_W), .CNT_W(CNT_W), .FIFO_DEPTH(DEPTH), .LAT_W(LAT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .pat_mode(mode), .alt_en(alt_en),
    .latency(lat), .win_in(win), .ev_valid(ev_valid), .ev_ready(rdy), .ev_ts(ev_ts),
    .ev_mask(ev_mask), .ev_paired(ev_paired), .err_count(err_count),
    .burst_count(burst_count), .overflow(overflow)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_window(input logic [1:0] md, input int ph);
    if (md == 2'b01) return 4'hF;
    if (md == 2'b10) return ph ? 4'hA : 4'h5;
    return 4'h0;
  endfunction

  // Driver: drives one capture, updates the model, waits for the edge.
  task automatic step(input logic [3:0] flip, input bit do_start);
    bit chk, pop, push, flt, pr;
    start = do_start;
    chk = !do_start && (m_run != 0) && (m_lat == 0);
    win = chk ? (exp_window(mode, m_phase) ^ flip) : flip;
    pop = (m_occ > 0) && rdy;
    push = 1'b0;
    if (do_start) begin
      m_run = 1; m_lat = int'(lat); m_phase = 0; m_tick = 0; m_prev = 4'h0;
      m_err = 0; m_burst = 0; m_occ = 0; m_ovf = 0;
      exp_q.delete();
    end else begin
      if (chk) begin
        flt = (flip != 4'h0);
        pr = flt && alt_en && (((m_prev == 4'b1000) && (flip == 4'b0010)) ||
                               ((m_prev == 4'b0100) && (flip == 4'b0001)));
        if (flt) begin
          if (m_err < SAT) m_err++;
          if ((m_prev != 4'h0) && !pr && (m_burst < SAT)) m_burst++;
          if (m_occ < DEPTH) begin
            push = 1'b1;
            exp_q.push_back({m_tick[31:0], flip, pr});
          end else m_ovf = 1;
        end
        m_prev = flip;
        m_phase ^= 1;
      end else m_prev = 4'h0;
      if (m_lat > 0) m_lat--;
      m_occ = m_occ - int'(pop) + int'(push);
      m_tick++;
    end
    @(posedge clk);
    #2;
  endtask

  task automatic counts(input string req);
    check({req, " err_count"}, 64'(err_count), 64'(m_err));
    check({req, " burst_count"}, 64'(burst_count), 64'(m_burst));
    check({req, " overflow"}, 64'(overflow), 64'(m_ovf));
  endtask

  // Monitor: compares each transferred event with the scoreboard front (R4 R5 R7 R9).
  always @(negedge clk) begin
    if (rst_n && ev_valid && rdy && !start) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9 unexpected event actual=%0h expected=none", {ev_ts, ev_mask, ev_paired});
      end else begin
        check("R9 event order/content", 64'({ev_ts, ev_mask, ev_paired}), 64'(exp_q.pop_front()));
      end
    end
  end

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [TS_W-1:0] held;
    #20 rst_n = 1'b1;
    @(posedge clk); #2;
    // R1 reset state
    check("R1 err_count", 64'(err_count), 0);
    check("R1 burst_count", 64'(burst_count), 0);
    check("R1 ev_valid", 64'(ev_valid), 0);
    check("R1 overflow", 64'(overflow), 0);
    for (int i = 0; i < 4; i++) step(4'hF, 0);
    check("R1 idle before start err", 64'(err_count), 0);
    check("R1 idle before start valid", 64'(ev_valid), 0);

    // R2 R4 R5 R6 zeros pattern, latency 3
    mode = 2'b00; lat = 8'd3;
    step(4'h0, 1);
    for (int i = 0; i < 3; i++) step(4'hF, 0);
    check("R2 latency window ignored", 64'(err_count), 0);
    step(4'h0, 0); step(4'h0, 0);
    step(4'b0011, 0); step(4'h0, 0);
    counts("R4 single fault");
    step(4'b0110, 0); step(4'b0001, 0); step(4'h0, 0); step(4'h0, 0);
    counts("R6 consecutive faults");
    check("R6 burst value", 64'(burst_count), 1);

    // R3 all ones
    mode = 2'b01;
    step(4'h0, 1);
    for (int i = 0; i < 3; i++) step(4'h0, 0);
    step(4'h0, 0); step(4'b1111, 0); step(4'h0, 0); step(4'h0, 0);
    counts("R3 ones pattern");
    check("R3 ones err", 64'(err_count), 1);

    // R3 checkerboard phase alternation
    mode = 2'b10;
    step(4'h0, 1);
    for (int i = 0; i < 3; i++) step(4'h0, 0);
    for (int i = 0; i < 5; i++) step(4'h0, 0);
    check("R3 checkerboard clean", 64'(err_count), 0);
    step(4'b0100, 0); step(4'h0, 0); step(4'h0, 0);
    counts("R3 checkerboard fault");

    // R2 latency 0 with reserved mode
    mode = 2'b11; lat = 8'd0;
    step(4'h0, 1);
    step(4'b1001, 0); step(4'h0, 0); step(4'h0, 0);
    counts("R2 zero latency, R3 reserved mode");
    check("R2 first edge checked", 64'(err_count), 1);

    // R7 alternating-enable pairs
    mode = 2'b00; lat = 8'd3; alt_en = 1'b1;
    step(4'h0, 1);
    for (int i = 0; i < 3; i++) step(4'h0, 0);
    step(4'b1000, 0); step(4'b0010, 0); step(4'h0, 0);
    step(4'b0100, 0); step(4'b0001, 0); step(4'h0, 0); step(4'h0, 0);
    counts("R7 pairs");
    check("R7 pair not burst", 64'(burst_count), 0);
    step(4'b0100, 0); step(4'b0001, 0); step(4'b0001, 0); step(4'h0, 0); step(4'h0, 0);
    check("R7 fault after pair is burst", 64'(burst_count), 1);
    alt_en = 1'b0;
    step(4'b1000, 0); step(4'b0010, 0); step(4'h0, 0); step(4'h0, 0);
    check("R7 alt off pair counts as burst", 64'(burst_count), 2);
    counts("R7 alt off");

    // R8 saturation
    step(4'h0, 1);
    for (int i = 0; i < 3; i++) step(4'h0, 0);
    for (int i = 0; i < 10; i++) step(4'b0101, 0);
    step(4'h0, 0); step(4'h0, 0);
    check("R8 err saturates", 64'(err_count), SAT);
    check("R8 burst saturates", 64'(burst_count), SAT);
    counts("R8");

    // R9 R10 back-pressure and overflow
    rdy = 1'b0;
    step(4'h0, 1);
    for (int i = 0; i < 3; i++) step(4'h0, 0);
    for (int i = 0; i < 6; i++) begin step(4'b0010, 0); step(4'h0, 0); end
    check("R10 overflow set", 64'(overflow), 1);
    check("R9 valid under stall", 64'(ev_valid), 1);
    check("R9 head event", 64'({ev_ts, ev_mask, ev_paired}), 64'(exp_q[0]));
    held = ev_ts;
    step(4'h0, 0); step(4'h0, 0);
    check("R9 held stable", 64'(ev_ts), 64'(held));
    rdy = 1'b1;
    for (int i = 0; i < 6; i++) step(4'h0, 0);
    check("R10 drained count", 64'(exp_q.size()), 0);
    check("R10 drained valid", 64'(ev_valid), 0);
    check("R10 overflow sticky", 64'(overflow), 1);

    // R11 start clears
    rdy = 1'b0;
    step(4'h0, 1);
    for (int i = 0; i < 3; i++) step(4'h0, 0);
    step(4'b1100, 0); step(4'h0, 0);
    check("R11 pending before start", 64'(ev_valid), 1);
    step(4'h0, 1);
    check("R11 queue emptied", 64'(ev_valid), 0);
    check("R11 err cleared", 64'(err_count), 0);
    check("R11 overflow cleared", 64'(overflow), 0);
    rdy = 1'b1;
    step(4'h0, 0); step(4'h0, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule